// File: doc/BRIEF.md
# Transmit Descriptor Status Write-back Sequencer

This block decides when each transmit descriptor gets its done-status written back to memory and when the ring head pointer moves past it. Descriptors arrive one at a time, in ring order, once their data buffers have been copied into the on-chip packet buffer. Each arrival carries two flags and a frame count. The early-report flag asks for a write-back as soon as the buffer is stored. The on-wire flag asks for a write-back only after the packet has actually left the MAC. The frame count is the number of frames a segmentation context expands into.

Arrivals wait in a small queue. The oldest entry retires at most once per cycle. An on-wire entry at the front of the queue blocks retirement. It stays blocked until the MAC reports enough completed frames, or reports a transmit error. While it is blocked, the head pointer and every later write-back are frozen. The queue still accepts newly fetched descriptors behind it until it fills.

Top module: `tx_wb_sequencer`

## Requirements
- R1: After reset, `head_ptr` is 0, `wb_req` is 0 and `in_ready` is 1.
- R2: A descriptor with `in_rs`=1 and `in_rps`=0 that reaches an empty queue retires one cycle after it is accepted. `wb_req` pulses for one cycle with `wb_idx` equal to its ring index, and `head_ptr` advances by one.
- R3: A descriptor with both flags clear advances `head_ptr` without raising `wb_req`.
- R4: While a descriptor with `in_rps`=1 is at the front of the queue and not yet released, `head_ptr` stays unchanged and `wb_req` stays 0, including for later descriptors.
- R5: A held descriptor whose frame count is 0 or 1 is released by a single `tx_done` pulse. In the cycle after that pulse, `wb_req`=1, `wb_idx` equals its index and `head_ptr` advances.
- R6: A `tx_err` pulse releases the held descriptor in the next cycle, whatever number of frames remains.
- R7: A held descriptor with frame count N greater than 1 is released only in the cycle after its Nth `tx_done` pulse.
- R8: `tx_done` and `tx_err` pulses that arrive while no held descriptor is at the front are ignored, and do not count toward a descriptor that arrives later.
- R9: The queue keeps accepting descriptors during a hold. `in_ready` is 0 exactly when DEPTH entries are queued.
- R10: Retirements happen at most one per cycle, in arrival order. After a release, queued descriptors retire on consecutive cycles.
- R11: `head_ptr` wraps from `ring_len`-1 to 0. The ring index of each descriptor follows the same wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_len | input | IDX_W | Number of descriptors in the ring |
| in_valid | input | 1 | A fetched descriptor is offered |
| in_ready | output | 1 | Queue can accept a descriptor |
| in_rs | input | 1 | Early-report flag: write back once the buffer is stored |
| in_rps | input | 1 | On-wire flag: write back once the packet is sent |
| in_frames | input | FR_W | Frames in the descriptor's packet or segmentation context (0 counts as 1) |
| tx_done | input | 1 | MAC pulse: one frame transmitted |
| tx_err | input | 1 | MAC pulse: transmission failed |
| wb_req | output | 1 | One-cycle done-bit write-back request |
| wb_idx | output | IDX_W | Ring index for the write-back request |
| head_ptr | output | IDX_W | Ring head pointer |

## Verification
A wrong internal state in this block shows up at the ports within a cycle or two of the event that exposes it. If the frame counter starts from a stale value, a held descriptor is released one or more `tx_done` pulses too early, so `head_ptr` moves while it should be frozen. A corrupted queue pointer or fill count appears as an out-of-order or repeated `wb_idx`, or as `in_ready` dropping at the wrong fill level. A bad wrap appears as a `head_ptr` at or above `ring_len` on the retirement that follows.

// File: rtl/tx_wb_sequencer.sv
module tx_wb_sequencer #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 8,
  parameter int FR_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ring_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_rs,
  input  logic             in_rps,
  input  logic [FR_W-1:0]  in_frames,
  input  logic             tx_done,
  input  logic             tx_err,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_idx,
  output logic [IDX_W-1:0] head_ptr
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = FR_W + 2;

  logic [EW-1:0]   mem [DEPTH];
  logic [PW-1:0]   rd_p, wr_p;
  logic [CW-1:0]   q_cnt;
  logic [FR_W-1:0] sent;

  logic [EW-1:0]   front;
  logic            f_rs, f_rps, q_nonempty, push, release_hold, retire;
  logic [FR_W-1:0] f_fr, need;
  logic [FR_W:0]   sent_p1;
  logic [IDX_W-1:0] head_nxt;

  assign front      = mem[rd_p];
  assign f_rs       = front[EW-1];
  assign f_rps      = front[EW-2];
  assign f_fr       = front[FR_W-1:0];
  assign need       = (f_fr == '0) ? FR_W'(1) : f_fr;
  assign sent_p1    = {1'b0, sent} + 1'b1;

  assign q_nonempty   = q_cnt != '0;
  assign in_ready     = q_cnt != CW'(DEPTH);
  assign push         = in_valid && in_ready;
  assign release_hold = tx_err || (tx_done && sent_p1 >= {1'b0, need});
  assign retire       = q_nonempty && (!f_rps || release_hold);
  assign head_nxt     = (head_ptr == ring_len - 1'b1) ? '0 : head_ptr + 1'b1;

  always_ff @(posedge clk)
    if (push) mem[wr_p] <= {in_rs, in_rps, in_frames};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_p     <= '0;
      wr_p     <= '0;
      q_cnt    <= '0;
      sent     <= '0;
      wb_req   <= 1'b0;
      wb_idx   <= '0;
      head_ptr <= '0;
    end else begin
      if (push)
        wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      if (retire)
        rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
      q_cnt <= q_cnt + CW'(push) - CW'(retire);

      if (retire)
        sent <= '0;
      else if (q_nonempty && f_rps && tx_done)
        sent <= sent + 1'b1;

      wb_req <= retire && (f_rs || f_rps);
      if (retire) begin
        wb_idx   <= head_ptr;
        head_ptr <= head_nxt;
      end
    end
  end
endmodule

module tx_wb_sequencer_chk #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [IDX_W-1:0]             ring_len,
  input logic                         in_ready,
  input logic                         tx_done,
  input logic                         tx_err,
  input logic                         wb_req,
  input logic [IDX_W-1:0]             wb_idx,
  input logic [IDX_W-1:0]             head_ptr,
  input logic [$clog2(DEPTH+1)-1:0]   q_cnt,
  input logic                         f_rps
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  // R9
  q_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt <= DEPTH) && (!in_ready -> q_cnt == DEPTH));

  // R4
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && q_cnt != 0 && f_rps && !tx_done && !tx_err) |=> ($stable(head_ptr) && !wb_req));

  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && q_cnt == 0) |=> ($stable(head_ptr) && !wb_req));

  // R2
  wb_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wb_req) |-> (wb_idx == $past(head_ptr) && (ring_len == 1 || head_ptr != $past(head_ptr))));

  // R11
  head_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_len != 0) |-> (head_ptr < ring_len));
endmodule

bind tx_wb_sequencer tx_wb_sequencer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_len(ring_len), .in_ready(in_ready),
  .tx_done(tx_done), .tx_err(tx_err), .wb_req(wb_req), .wb_idx(wb_idx),
  .head_ptr(head_ptr), .q_cnt(q_cnt), .f_rps(f_rps)
);

// File: tb/tb_tx_wb_sequencer.sv
`timescale 1ns/100ps
module tb_tx_wb_sequencer;
  localparam int DEPTH = 4, IDX_W = 8, FR_W = 6;

  logic clk = 0, rst_n = 0;
  logic [IDX_W-1:0] ring_len = 8;
  logic in_valid = 0, in_rs = 0, in_rps = 0, tx_done = 0, tx_err = 0;
  logic [FR_W-1:0] in_frames = 0;
  logic in_ready, wb_req;
  logic [IDX_W-1:0] wb_idx, head_ptr;

  always #2.5 clk = ~clk;

  tx_wb_sequencer #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FR_W(FR_W)) dut (
    .clk, .rst_n, .ring_len, .in_valid, .in_ready, .in_rs, .in_rps, .in_frames,
    .tx_done, .tx_err, .wb_req, .wb_idx, .head_ptr);

  int checks = 0, fails = 0, cyc = 0, wb_n = 0;
  int wb_i[64];
  int wb_c[64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && wb_req && wb_n < 64) begin
      wb_i[wb_n] = int'(wb_idx);
      wb_c[wb_n] = cyc;
      wb_n = wb_n + 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic push(bit rs, bit rps, int fr);
    @(negedge clk);
    in_valid = 1; in_rs = rs; in_rps = rps; in_frames = FR_W'(fr);
    @(negedge clk);
    in_valid = 0; in_rs = 0; in_rps = 0; in_frames = 0;
  endtask

  task automatic pulse(bit err);
    @(negedge clk);
    tx_done = !err; tx_err = err;
    @(negedge clk);
    tx_done = 0; tx_err = 0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 head", int'(head_ptr), 0);
    chk("R1 wb_req", int'(wb_req), 0);
    chk("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_rs_only();
    push(1, 0, 1);
    @(negedge clk);
    chk("R2 wb_req", int'(wb_req), 1);
    chk("R2 wb_idx", int'(wb_idx), 0);
    chk("R2 head", int'(head_ptr), 1);
    @(negedge clk);
    chk("R2 single pulse", int'(wb_req), 0);
  endtask

  task automatic t_no_flags();
    push(0, 0, 1);
    @(negedge clk);
    chk("R3 head", int'(head_ptr), 2);
    chk("R3 no wb", int'(wb_req), 0);
  endtask

  task automatic t_hold_release();
    int n0;
    push(0, 1, 1);
    push(1, 0, 1);
    n0 = wb_n;
    repeat (5) @(negedge clk);
    chk("R4 head held", int'(head_ptr), 2);
    chk("R4 no later wb", wb_n - n0, 0);
    pulse(0);
    chk("R5 wb_req", int'(wb_req), 1);
    chk("R5 wb_idx", int'(wb_idx), 2);
    chk("R5 head", int'(head_ptr), 3);
    @(negedge clk);
    chk("R10 next wb_idx", int'(wb_idx), 3);
    chk("R10 next head", int'(head_ptr), 4);
    @(negedge clk);
    chk("R10 idle", int'(wb_req), 0);
  endtask

  task automatic t_error();
    push(0, 1, 5);
    pulse(0);
    chk("R6 held after one frame", int'(head_ptr), 4);
    pulse(1);
    chk("R6 wb_req", int'(wb_req), 1);
    chk("R6 wb_idx", int'(wb_idx), 4);
    chk("R6 head", int'(head_ptr), 5);
  endtask

  task automatic t_segments();
    push(1, 1, 3);
    pulse(0);
    pulse(0);
    chk("R7 held after two frames", int'(head_ptr), 5);
    chk("R7 no wb yet", int'(wb_req), 0);
    pulse(0);
    chk("R7 wb_idx", int'(wb_idx), 5);
    chk("R7 head", int'(head_ptr), 6);
  endtask

  task automatic t_ignored();
    repeat (3) pulse(0);
    pulse(1);
    chk("R8 head unchanged", int'(head_ptr), 6);
    chk("R8 no wb", int'(wb_req), 0);
    push(0, 1, 1);
    repeat (3) @(negedge clk);
    chk("R8 stale pulses not counted", int'(head_ptr), 6);
    pulse(0);
    chk("R8 wb_idx", int'(wb_idx), 6);
    chk("R8 head", int'(head_ptr), 7);
  endtask

  task automatic t_full_wrap();
    int n0;
    push(1, 1, 1);
    for (int k = 0; k < 3; k++) push(1, 0, 1);
    chk("R9 full", int'(in_ready), 0);
    chk("R9 head held", int'(head_ptr), 7);
    n0 = wb_n;
    pulse(0);
    chk("R11 wrap head", int'(head_ptr), 0);
    chk("R11 wb_idx", int'(wb_idx), 7);
    repeat (4) @(negedge clk);
    chk("R10 head", int'(head_ptr), 3);
    chk("R10 count", wb_n - n0, 4);
    chk("R9 ready again", int'(in_ready), 1);
    for (int k = 0; k < 4; k++) begin
      chk("R10 order", wb_i[n0 + k], (k + 7) % 8);
      chk("R10 back-to-back", wb_c[n0 + k] - wb_c[n0], k);
    end
  endtask

  initial begin
    t_reset();
    t_rs_only();
    t_no_flags();
    t_hold_release();
    t_error();
    t_segments();
    t_ignored();
    t_full_wrap();
    summary();
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end
endmodule